// File: doc/BRIEF.md
# Asynchronous SRAM Sequencing Controller

This block sits between a clocked request port and an asynchronous 16-bit static RAM. Each accepted request becomes one complete memory cycle on the pins. The controller drives both chip selects, where one is low-true and the other high-true. It also drives write enable, output enable, two per-byte lane selects, a 22-bit word address and a tri-state data bus. For a read it captures the returned word. Each phase of the pin sequence is held for a whole number of clock cycles. These counts are computed at elaboration from the memory's nanosecond minimums and the clock period. Each count is ceiling(time / period) plus one cycle of margin.

A request is taken only while `ready` is high. The address, data and lane mask are then frozen until the cycle ends. A cycle runs through these phases in order:
- one address-only cycle with every strobe inactive;
- the strobe phases: select setup, write pulse and hold for a write, or the access phase for a read;
- a recovery phase with every strobe inactive, which lets the memory release the data bus.

A write lands only where all strobes overlap. Write enable is the last strobe to go active and the first to go inactive, so that window is exactly the write-enable pulse. Timing for the faster or the slower speed grade is chosen by one parameter.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset, `ready` is 1 and `rd_valid` and `done` are 0. The pins are inactive: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lb_n`=1, `mem_ub_n`=1.
- R2: A request (`req`=1) is accepted only in a cycle where `ready`=1. `ready` is 0 from the clock after acceptance until the cycle completes. A request raised while `ready`=0 has no effect on the memory.
- R3: For every write, `mem_we_n` is low for exactly NWP cycles. With c(t)=ceil(t/Tclk)+1, NWP = max(c(tWP), c(tDW), c(tAW)-1). Both chip selects are active in the cycle before write enable falls and in the cycle after it rises. At 20 ns and the fast grade, NWP is 3.
- R4: When `mem_we_n` rises, the write data has been stable on `mem_dq` for at least tDW. The chip selects have been active for at least tAW.
- R5: For every read, `mem_oe_n` is low for exactly NRD = max(c(tAA), c(tOE), c(tRC)) cycles, which is 4 at 20 ns and the fast grade. The bus is captured at the end of that window. `rd_valid` is high for exactly one clock, in the clock where `mem_oe_n` returns high.
- R6: Bit 0 of `req_be` enables the low lane, `mem_lb_n`, which covers data bits 7:0. Bit 1 enables the high lane, `mem_ub_n`, which covers bits 15:8. A lane select is driven low only for an enabled lane and only while the chip is selected. A lane disabled on a read returns 0 in `rd_data`. A write with `req_be`=0 leaves the memory unchanged.
- R7: `mem_we_n` and `mem_oe_n` are never low in the same cycle. `mem_oe_n` stays high for the whole of a write.
- R8: After `mem_oe_n` rises, at least c(tHZ) cycles pass with every strobe inactive before the controller drives `mem_dq`. The bus is driven only during write cycles.
- R9: `mem_addr` changes only in cycles where every strobe is inactive, both in that cycle and in the one before.
- R10: With `SLOW_GRADE`=1 the slower timing set applies. At 20 ns this gives a 4-cycle write pulse and a 5-cycle read access.
- R11: `done` is high for one clock when a cycle completes. That clock is the first one in which `ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, taken when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Controller idle, can accept a request |
| done | output | 1 | One-clock pulse at the end of a cycle |
| rd_data | output | DATA_W | Captured read word, disabled lanes zero |
| rd_valid | output | 1 | One-clock pulse when `rd_data` is new |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-lane select, active low |
| mem_ub_n | output | 1 | High-lane select, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The bench measures every pin phase in cycles and compares it with counts worked out from the nanosecond minimums. A pulse that is one cycle short would break the write-pulse or access figure. A wrong maximum in the count formula would do the same. Lane masks are swept through all four values, including an empty mask, against a separate memory model. A swapped or ignored byte select therefore corrupts read-back or leaves stale bytes. The sweep also covers reads that are followed directly by writes, which would expose a missing recovery gap. A request raised while the controller is busy is checked through read-back of the address it named. Two further errors show up as differing cycle counts: a speed-grade switch that has no effect, and an address that moves while the chip is selected.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

    // Minimum times of one speed grade, in nanoseconds
    typedef struct packed {
        int unsigned t_cycle;   // read and write cycle
        int unsigned t_acc;     // address / select access
        int unsigned t_oe;      // output enable access
        int unsigned t_wp;      // write pulse
        int unsigned t_aw;      // address and select valid to end of write
        int unsigned t_dw;      // data setup to end of write
        int unsigned t_hz;      // bus release after deselect
    } timing_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD,
        PH_RACC,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic cs;
        logic we_n;
        logic oe_n;
        logic drive;
        logic lanes_on;
    } strobe_t;

    function automatic timing_t grade_times(input bit slow);
        timing_t t;
        if (slow) begin
            t = '{t_cycle: 70, t_acc: 70, t_oe: 35, t_wp: 55,
                  t_aw: 65, t_dw: 35, t_hz: 25};
        end else begin
            t = '{t_cycle: 55, t_acc: 55, t_oe: 25, t_wp: 40,
                  t_aw: 50, t_dw: 25, t_hz: 20};
        end
        return t;
    endfunction

    // ceiling(ns / period) plus one margin cycle
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period);
        return (ns + period - 1) / period + 1;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic strobe_t strobes_for(input phase_e ph);
        strobe_t s;
        s = '{cs_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1,
              drive: 1'b0, lanes_on: 1'b0};
        case (ph)
            PH_WSETUP, PH_WHOLD: begin
                s.cs_n = 1'b0; s.cs = 1'b1; s.drive = 1'b1; s.lanes_on = 1'b1;
            end
            PH_WPULSE: begin
                s.cs_n = 1'b0; s.cs = 1'b1; s.drive = 1'b1; s.lanes_on = 1'b1;
                s.we_n = 1'b0;
            end
            PH_RACC: begin
                s.cs_n = 1'b0; s.cs = 1'b1; s.oe_n = 1'b0; s.lanes_on = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_decode.sv
`timescale 1ns/1ps
module sram_lane_decode #(
    parameter int unsigned LANES = 2
) (
    input  logic             en,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] sel_n
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sel_n[l] = !(en && be[l]);
    end
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data[l*8 +: 8] <= '0;
            end else if (sample) begin
                rd_data[l*8 +: 8] <= be[l] ? bus[l*8 +: 8] : 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= sample;
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter bit          SLOW_GRADE    = 1'b0,
    parameter int unsigned ADDR_W        = 22,
    parameter int unsigned DATA_W        = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                ready,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                mem_cs_n,
    output logic                mem_cs,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_lb_n,
    output logic                mem_ub_n,
    output logic [ADDR_W-1:0]   mem_addr,
    inout  wire  [DATA_W-1:0]   mem_dq
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam timing_t     TM    = grade_times(SLOW_GRADE);

    localparam int unsigned C_WP  = ns_to_cyc(TM.t_wp,    CLK_PERIOD_NS);
    localparam int unsigned C_DW  = ns_to_cyc(TM.t_dw,    CLK_PERIOD_NS);
    localparam int unsigned C_AW  = ns_to_cyc(TM.t_aw,    CLK_PERIOD_NS);
    localparam int unsigned C_CYC = ns_to_cyc(TM.t_cycle, CLK_PERIOD_NS);
    localparam int unsigned N_AS  = ns_to_cyc(0,          CLK_PERIOD_NS);
    localparam int unsigned N_WP  = max3(C_WP, C_DW, (C_AW > N_AS) ? C_AW - N_AS : 1);
    localparam int unsigned N_WH  = (C_CYC > N_AS + N_WP) ? C_CYC - N_AS - N_WP : 1;
    localparam int unsigned N_RD  = max3(ns_to_cyc(TM.t_acc, CLK_PERIOD_NS),
                                         ns_to_cyc(TM.t_oe,  CLK_PERIOD_NS), C_CYC);
    localparam int unsigned N_REC = ns_to_cyc(TM.t_hz, CLK_PERIOD_NS);
    localparam int unsigned N_MAX = max3(max3(N_WP, N_WH, N_RD), N_REC, N_AS);
    localparam int unsigned CNT_W = $clog2(N_MAX + 1);

    phase_e             phase_q, phase_d;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_exp;
    logic               accept;
    logic               sample;

    logic               we_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [LANES-1:0]   be_q;

    strobe_t            stb_d, stb_q;
    logic [LANES-1:0]   lane_n_d, lane_n_q;
    logic               done_q;
    logic               drv_q;

    assign accept = req && (phase_q == PH_IDLE);
    assign sample = (phase_q == PH_RACC) && tmr_exp;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // Phase sequencing: every strobe phase runs for its computed count
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    phase_d  = PH_ADDR;
                    tmr_load = 1'b1;
                end
            end
            PH_ADDR: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (we_q) begin
                        phase_d = PH_WSETUP;
                        tmr_val = CNT_W'(N_AS - 1);
                    end else begin
                        phase_d = PH_RACC;
                        tmr_val = CNT_W'(N_RD - 1);
                    end
                end
            end
            PH_WSETUP: begin
                if (tmr_exp) begin
                    phase_d  = PH_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_WP - 1);
                end
            end
            PH_WPULSE: begin
                if (tmr_exp) begin
                    phase_d  = PH_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_WH - 1);
                end
            end
            PH_WHOLD, PH_RACC: begin
                if (tmr_exp) begin
                    phase_d  = PH_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_REC - 1);
                end
            end
            PH_RECOV: begin
                if (tmr_exp) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    assign stb_d = strobes_for(phase_d);

    sram_lane_decode #(.LANES(LANES)) u_lanes (
        .en    (stb_d.lanes_on),
        .be    (be_q),
        .sel_n (lane_n_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            stb_q    <= strobes_for(PH_IDLE);
            lane_n_q <= '1;
            done_q   <= 1'b0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
        end else begin
            phase_q  <= phase_d;
            stb_q    <= stb_d;
            lane_n_q <= lane_n_d;
            done_q   <= (phase_q == PH_RECOV) && tmr_exp;
            if (accept) begin
                we_q    <= req_we;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
        end
    end

    sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .be       (be_q),
        .bus      (mem_dq),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign drv_q    = stb_q.drive;
    assign mem_dq   = drv_q ? wdata_q : {DATA_W{1'bz}};
    assign mem_cs_n = stb_q.cs_n;
    assign mem_cs   = stb_q.cs;
    assign mem_we_n = stb_q.we_n;
    assign mem_oe_n = stb_q.oe_n;
    assign mem_lb_n = lane_n_q[0];
    assign mem_ub_n = lane_n_q[1];
    assign mem_addr = addr_q;
    assign ready    = (phase_q == PH_IDLE);
    assign done     = done_q;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sram_seq_ctrl_chk #(
    parameter int unsigned ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              ready,
    input logic              rd_valid,
    input logic              cs_n,
    input logic              cs,
    input logic              we_n,
    input logic              oe_n,
    input logic              lb_n,
    input logic              ub_n,
    input logic [ADDR_W-1:0] addr,
    input logic              drive
);
    // R7
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));

    // R3
    we_inside_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!cs_n && cs && $past(!cs_n)));

    // R6
    lane_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (!lb_n || !ub_n) |-> (!cs_n && cs));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(addr));

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && req) |=> !ready);

    // R5
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R8
    drive_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        drive |-> (oe_n && $past(oe_n)));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .ready    (ready),
    .rd_valid (rd_valid),
    .cs_n     (mem_cs_n),
    .cs       (mem_cs),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .lb_n     (mem_lb_n),
    .ub_n     (mem_ub_n),
    .addr     (mem_addr),
    .drive    (drv_q)
);

// File: tb/tb_sram_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sram_seq_ctrl;
    localparam int PER = 20;

    function automatic int bcyc(input int ns);
        return (ns + PER - 1) / PER + 1;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_WP   = imax(imax(bcyc(40), bcyc(25)), bcyc(50) - 1);
    localparam int EXP_RD   = imax(imax(bcyc(55), bcyc(25)), bcyc(55));
    localparam int EXP_REC  = bcyc(20);
    localparam int EXP_WP_S = imax(imax(bcyc(55), bcyc(35)), bcyc(65) - 1);
    localparam int EXP_RD_S = imax(imax(bcyc(70), bcyc(35)), bcyc(70));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_we = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ready, done, rd_valid;
    logic [15:0] rd_data;
    logic        cs_n, cs, we_n, oe_n, lb_n, ub_n;
    logic [21:0] maddr;
    wire  [15:0] dq;

    logic        s_req = 1'b0, s_we = 1'b0;
    logic        s_ready, s_done, s_rv;
    logic [15:0] s_rd;
    logic        s_cs_n, s_cs, s_we_n, s_oe_n, s_lb_n, s_ub_n;
    logic [21:0] s_addr;
    wire  [15:0] s_dq;

    int n_chk = 0;
    int n_fail = 0;

    always #(PER/2) clk = ~clk;

    sram_seq_ctrl dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ready(ready), .done(done),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_cs_n(cs_n), .mem_cs(cs),
        .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_lb_n(lb_n), .mem_ub_n(ub_n),
        .mem_addr(maddr), .mem_dq(dq)
    );

    sram_seq_ctrl #(.SLOW_GRADE(1'b1)) dut_slow (
        .clk(clk), .rst(rst), .req(s_req), .req_we(s_we), .req_addr(22'h000003),
        .req_wdata(16'h1234), .req_be(2'b11), .ready(s_ready), .done(s_done),
        .rd_data(s_rd), .rd_valid(s_rv), .mem_cs_n(s_cs_n), .mem_cs(s_cs),
        .mem_we_n(s_we_n), .mem_oe_n(s_oe_n), .mem_lb_n(s_lb_n), .mem_ub_n(s_ub_n),
        .mem_addr(s_addr), .mem_dq(s_dq)
    );

    // Asynchronous memory model: 16 words selected by the low address bits
    logic [15:0] mem_arr [16];
    wire rd_drv = !cs_n && cs && we_n && !oe_n;
    assign dq[7:0]  = (rd_drv && !lb_n) ? mem_arr[maddr[3:0]][7:0]  : 8'hzz;
    assign dq[15:8] = (rd_drv && !ub_n) ? mem_arr[maddr[3:0]][15:8] : 8'hzz;
    always @(posedge we_n) begin
        if (!cs_n && cs) begin
            if (!lb_n) mem_arr[maddr[3:0]][7:0]  <= dq[7:0];
            if (!ub_n) mem_arr[maddr[3:0]][15:8] <= dq[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Pin monitor, sampled away from the active edge
    bit          mon_on = 1'b0;
    logic [1:0]  cur_be = 2'b00;
    logic        p_we_n = 1, p_oe_n = 1, p_cs_act = 0, p_rv = 0;
    logic [15:0] p_dq = '0;
    logic [21:0] p_addr = '0;
    int we_cnt = 0, oe_cnt = 0, cs_cnt = 0, dq_st = 0, idle_cnt = 1000, rv_cnt = 0;
    bit saw_both = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            logic cs_act;
            cs_act = !cs_n && cs;
            if (!we_n && !oe_n) saw_both = 1;
            if (cs_act) cs_cnt++; else cs_cnt = 0;
            if (!we_n) we_cnt++;
            if (!oe_n) begin oe_cnt++; idle_cnt = 0; end else idle_cnt++;
            if (rd_valid) rv_cnt++;
            if (cs_act && oe_n) begin
                if (!p_cs_act || dq !== p_dq) dq_st = 1; else dq_st++;
            end
            if (!p_we_n && we_n) begin
                chk(we_cnt == EXP_WP, "R3 write pulse cycles", we_cnt, EXP_WP);
                chk(cs_act, "R3 select held after write enable", int'(cs_act), 1);
                chk((cs_cnt - 1) * PER >= 50, "R4 select to end of write ns", (cs_cnt - 1) * PER, 50);
                chk((dq_st - 1) * PER >= 25, "R4 data setup ns", (dq_st - 1) * PER, 25);
                chk(!saw_both && oe_n, "R7 output enable during write", int'(saw_both), 0);
                chk(lb_n == !cur_be[0], "R6 low lane select", int'(lb_n), int'(!cur_be[0]));
                chk(ub_n == !cur_be[1], "R6 high lane select", int'(ub_n), int'(!cur_be[1]));
                we_cnt = 0;
                saw_both = 0;
            end
            if (!p_oe_n && oe_n) begin
                chk(oe_cnt == EXP_RD, "R5 read access cycles", oe_cnt, EXP_RD);
                chk(rd_valid && !p_rv, "R5 valid at end of access", int'(rd_valid), 1);
                oe_cnt = 0;
            end
            if (p_rv && !rd_valid) begin
                chk(rv_cnt == 1, "R5 valid width", rv_cnt, 1);
                rv_cnt = 0;
            end
            if (!p_cs_act && cs_act && oe_n) begin
                chk(idle_cnt - 1 >= EXP_REC, "R8 bus turnaround cycles", idle_cnt - 1, EXP_REC);
            end
            if (maddr != p_addr) begin
                chk(!p_cs_act && !cs_act && we_n && oe_n, "R9 address moved while selected",
                    int'(p_cs_act), 0);
            end
            p_we_n = we_n; p_oe_n = oe_n; p_cs_act = cs_act; p_rv = rd_valid;
            p_dq = dq; p_addr = maddr;
        end
    end

    // Slow-grade monitor
    int s_we_cnt = 0, s_oe_cnt = 0;
    logic s_pwe = 1, s_poe = 1;
    bit s_seen_w = 0, s_seen_r = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (!s_we_n) s_we_cnt++;
            if (!s_oe_n) s_oe_cnt++;
            if (!s_pwe && s_we_n) begin
                chk(s_we_cnt == EXP_WP_S, "R10 slow write pulse", s_we_cnt, EXP_WP_S);
                s_we_cnt = 0; s_seen_w = 1;
            end
            if (!s_poe && s_oe_n) begin
                chk(s_oe_cnt == EXP_RD_S, "R10 slow read access", s_oe_cnt, EXP_RD_S);
                s_oe_cnt = 0; s_seen_r = 1;
            end
            s_pwe = s_we_n; s_poe = s_oe_n;
        end
    end

    logic [15:0] shadow [16];

    function automatic logic [21:0] mk_addr(input int a);
        return {a[3:0], 14'h0, a[3:0]};
    endfunction
    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic issue(input bit we, input int a, input logic [15:0] d,
                         input logic [1:0] be, input bit spur,
                         output logic [15:0] rdv, output bit got);
        while (!ready) @(negedge clk);
        cur_be = be;
        req = 1; req_we = we; req_addr = mk_addr(a); req_wdata = d; req_be = be;
        @(negedge clk);
        req = 0;
        chk(!ready, "R2 ready drops after accept", int'(ready), 0);
        if (spur) begin
            req = 1; req_we = 1; req_addr = mk_addr(9); req_wdata = 16'hDEAD; req_be = 2'b11;
            @(negedge clk);
            req = 0;
        end
        got = 0;
        rdv = '0;
        while (!done) begin
            if (rd_valid) begin got = 1; rdv = rd_data; end
            @(negedge clk);
        end
        chk(ready, "R11 ready with done", int'(ready), 1);
        @(negedge clk);
        chk(!done, "R11 done width", int'(done), 0);
        if (we) begin
            for (int l = 0; l < 2; l++)
                if (be[l]) shadow[a][l*8 +: 8] = d[l*8 +: 8];
        end
    endtask

    task automatic do_read(input int a, input logic [1:0] be, input bit spur, input string tag);
        logic [15:0] v;
        bit g;
        issue(1'b0, a, 16'h0, be, spur, v, g);
        chk(g, {tag, " read valid seen"}, int'(g), 1);
        chk(v == (shadow[a] & lane_mask(be)), {tag, " read data"}, int'(v),
            int'(shadow[a] & lane_mask(be)));
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] v;
        bit g;
        issue(1'b1, a, d, be, 1'b0, v, g);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 while reset is held
        chk(ready && !rd_valid && !done, "R1 status in reset", int'(ready), 1);
        chk(cs_n && !cs && we_n && oe_n && lb_n && ub_n, "R1 pins inactive in reset",
            int'({cs_n, cs, we_n, oe_n, lb_n, ub_n}), 6'b101111);
        rst = 0;
        @(negedge clk);
        chk(ready && cs_n && !cs && we_n && oe_n && lb_n && ub_n, "R1 idle after reset",
            int'(ready), 1);
        p_addr = maddr;
        mon_on = 1;

        for (int a = 0; a < 16; a++)
            do_write(a, 16'(a * 16'h1111) ^ 16'h5A3C, 2'b11);
        for (int a = 0; a < 16; a++) begin
            logic [1:0] be;
            case (a % 4)
                0: be = 2'b01;
                1: be = 2'b10;
                2: be = 2'b11;
                default: be = 2'b00;
            endcase
            do_write(a, ~(16'(a * 16'h0F0F) + 16'h1357), be);
        end
        do_read(3, 2'b11, 1'b1, "R2 busy request ignored");
        do_read(9, 2'b11, 1'b0, "R2 busy request target");
        for (int a = 0; a < 16; a++) do_read(a, 2'b11, 1'b0, "R6 full word");
        do_read(6, 2'b01, 1'b0, "R6 low lane only");
        do_read(6, 2'b10, 1'b0, "R6 high lane only");
        do_read(6, 2'b00, 1'b0, "R6 no lane");
        do_write(6, 16'hC0DE, 2'b11);
        do_read(6, 2'b11, 1'b0, "R8 write after read");

        // Slow grade
        while (!s_ready) @(negedge clk);
        s_req = 1; s_we = 1; @(negedge clk); s_req = 0;
        while (!s_done) @(negedge clk);
        @(negedge clk);
        s_req = 1; s_we = 0; @(negedge clk); s_req = 0;
        while (!s_done) @(negedge clk);
        @(negedge clk);
        chk(s_seen_w && s_seen_r, "R10 slow cycles observed", int'(s_seen_w && s_seen_r), 1);

        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end
endmodule